// File: doc/BRIEF.md
# Vector Instruction Legality Checker

This block decides, for one class of packed-integer vector instruction, whether the instruction may run or which fault it must take. It looks at a handful of processor control bits (floating-point emulation, operating-system support for saving vector state, the task-switch marker), a capability bit that says the vector extension exists, the decoded lock and repeat prefixes, whether the source operand comes from memory, and the low bits of the effective address.

A decode or issue stage pulses `chk_valid` with the inputs for one instruction. One clock later the block presents exactly one verdict. It either signals that the instruction may proceed or raises one fault: undefined opcode, device not available, or general protection. When several faults apply, only the one with the highest priority is reported. Paging, segment limits and canonical-address checks belong to other logic.

Top module: `vec_legal_check`

## Requirements
- R1: When the floating-point emulation input `fpu_emulate` is 1, the verdict is undefined opcode (`flt_undef`).
- R2: When `vec_state_en` is 0 or `feature_present` is 0, the verdict is undefined opcode.
- R3: When any of `pfx_lock`, `pfx_rep` or `pfx_repne` is 1, the verdict is undefined opcode.
- R4: When `ctx_switched` is 1 and no undefined-opcode condition holds, the verdict is device not available (`flt_devna`).
- R5: With `src_is_mem` = 1, a nonzero value on any of the four bits of `ea_low` (address not a multiple of 16 bytes) gives the general-protection verdict (`flt_gp`), provided no higher-priority fault holds. A value of 0 gives no fault.
- R6: With `src_is_mem` = 0, `flt_gp` is never raised, whatever `ea_low` holds.
- R7: Faults are ranked undefined opcode, then device not available, then general protection. Only the highest-ranked applicable fault flag is raised.
- R8: When `res_valid` is 1, exactly one of `res_ok`, `flt_undef`, `flt_devna`, `flt_gp` is 1. `res_ok` is 1 only when no fault applies.
- R9: The verdict appears on the clock after the one on which `chk_valid` was sampled high, with `res_valid` = 1. When `chk_valid` was low, `res_valid`, `res_ok` and all fault flags are 0.
- R10: While `rst` is high and on the cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Inputs hold one instruction to judge |
| fpu_emulate | input | 1 | Floating-point emulation control bit |
| vec_state_en | input | 1 | OS support for saving vector state |
| feature_present | input | 1 | Vector extension capability bit |
| ctx_switched | input | 1 | Task-switched control bit |
| pfx_lock | input | 1 | Lock prefix decoded |
| pfx_rep | input | 1 | Repeat (F3h) prefix decoded |
| pfx_repne | input | 1 | Repeat-not-equal (F2h) prefix decoded |
| src_is_mem | input | 1 | Source operand is in memory |
| ea_low | input | 4 | Low bits of the effective address |
| res_valid | output | 1 | Verdict valid |
| res_ok | output | 1 | Instruction may execute |
| flt_undef | output | 1 | Undefined-opcode fault |
| flt_devna | output | 1 | Device-not-available fault |
| flt_gp | output | 1 | General-protection fault |

## Verification
The bench tries every combination of the three control bits, the capability bit and the three prefixes. Each combination runs with memory and register operands, and with both aligned and misaligned addresses. This exposes a wrong priority, for example a task-switch fault that hides a prefix fault, or two flags raised together. Register operands with misaligned addresses catch a design that checks alignment without looking at the operand source. Single misaligned bits, including the top bit of the four, catch a mask that covers too few bits. Idle cycles placed between checks catch a design whose flags stay set after a verdict or appear one cycle late.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int NUM_FAULT = 3;
  // index order is the priority order: lower index wins
  localparam int FI_UNDEF = 0;
  localparam int FI_DEVNA = 1;
  localparam int FI_GP    = 2;
  typedef logic [NUM_FAULT-1:0] fault_vec_t;
endpackage

// File: rtl/vlc_gate_check.sv
module vlc_gate_check (
  input  logic fpu_emulate,
  input  logic vec_state_en,
  input  logic feature_present,
  input  logic ctx_switched,
  input  logic pfx_lock,
  input  logic pfx_rep,
  input  logic pfx_repne,
  output logic undef_req,
  output logic devna_req
);
  logic enable_bad;
  logic prefix_bad;

  always_comb begin
    enable_bad = fpu_emulate | ~vec_state_en | ~feature_present;
    prefix_bad = pfx_lock | pfx_rep | pfx_repne;
    undef_req  = enable_bad | prefix_bad;
    devna_req  = ctx_switched;
  end
endmodule

// File: rtl/vlc_align_check.sv
module vlc_align_check #(
  parameter int ALIGN_BYTES = 16,
  localparam int AW = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1
) (
  input  logic          src_is_mem,
  input  logic [AW-1:0] ea_low,
  output logic          gp_req
);
  generate
    if (ALIGN_BYTES > 1) begin : g_align
      assign gp_req = src_is_mem & (|ea_low);
    end else begin : g_noalign
      logic unused_bits;
      assign unused_bits = src_is_mem ^ (^ea_low);
      assign gp_req = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/vlc_fault_prio.sv
module vlc_fault_prio
  import vlc_pkg::*;
(
  input  fault_vec_t req,
  output fault_vec_t grant,
  output logic       none
);
  logic [NUM_FAULT:0] seen;

  assign seen[0] = 1'b0;
  generate
    for (genvar i = 0; i < NUM_FAULT; i++) begin : g_rank
      assign grant[i]   = req[i] & ~seen[i];
      assign seen[i+1]  = seen[i] | req[i];
    end
  endgenerate
  assign none = ~seen[NUM_FAULT];
endmodule

// File: rtl/vec_legal_check.sv
module vec_legal_check
  import vlc_pkg::*;
#(
  parameter int ALIGN_BYTES = 16,
  localparam int AW = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chk_valid,
  input  logic          fpu_emulate,
  input  logic          vec_state_en,
  input  logic          feature_present,
  input  logic          ctx_switched,
  input  logic          pfx_lock,
  input  logic          pfx_rep,
  input  logic          pfx_repne,
  input  logic          src_is_mem,
  input  logic [AW-1:0] ea_low,
  output logic          res_valid,
  output logic          res_ok,
  output logic          flt_undef,
  output logic          flt_devna,
  output logic          flt_gp
);
  fault_vec_t req;
  fault_vec_t grant;
  logic       pass;

  vlc_gate_check u_gate (
    .fpu_emulate    (fpu_emulate),
    .vec_state_en   (vec_state_en),
    .feature_present(feature_present),
    .ctx_switched   (ctx_switched),
    .pfx_lock       (pfx_lock),
    .pfx_rep        (pfx_rep),
    .pfx_repne      (pfx_repne),
    .undef_req      (req[FI_UNDEF]),
    .devna_req      (req[FI_DEVNA])
  );

  vlc_align_check #(.ALIGN_BYTES(ALIGN_BYTES)) u_align (
    .src_is_mem(src_is_mem),
    .ea_low    (ea_low),
    .gp_req    (req[FI_GP])
  );

  vlc_fault_prio u_prio (
    .req  (req),
    .grant(grant),
    .none (pass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      flt_undef <= 1'b0;
      flt_devna <= 1'b0;
      flt_gp    <= 1'b0;
    end else begin
      res_valid <= chk_valid;
      res_ok    <= chk_valid & pass;
      flt_undef <= chk_valid & grant[FI_UNDEF];
      flt_devna <= chk_valid & grant[FI_DEVNA];
      flt_gp    <= chk_valid & grant[FI_GP];
    end
  end

  // verdict register checks
  assert_single_verdict_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $countones({res_ok, flt_undef, flt_devna, flt_gp}) == 1);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_ok || flt_undef || flt_devna || flt_gp));

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    $past(chk_valid && !rst) |-> res_valid);

  assert_emulate_undef_R1: assert property (@(posedge clk) disable iff (rst)
    $past(chk_valid && !rst && fpu_emulate) |-> flt_undef);

  assert_enable_undef_R2: assert property (@(posedge clk) disable iff (rst)
    $past(chk_valid && !rst && !(vec_state_en && feature_present)) |-> flt_undef);

  assert_prefix_undef_R3: assert property (@(posedge clk) disable iff (rst)
    $past(chk_valid && !rst && (pfx_lock || pfx_rep || pfx_repne)) |-> flt_undef);

  assert_register_no_gp_R6: assert property (@(posedge clk) disable iff (rst)
    $past(chk_valid && !rst && !src_is_mem) |-> !flt_gp);

  assert_rank_R7: assert property (@(posedge clk) disable iff (rst)
    flt_gp |-> !$past(ctx_switched));
endmodule

// File: tb/vec_legal_check_tb.sv
module vec_legal_check_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chk_valid = 1'b0;
  logic fpu_emulate = 1'b0, vec_state_en = 1'b1, feature_present = 1'b1, ctx_switched = 1'b0;
  logic pfx_lock = 1'b0, pfx_rep = 1'b0, pfx_repne = 1'b0, src_is_mem = 1'b0;
  logic [3:0] ea_low = 4'd0;
  logic res_valid, res_ok, flt_undef, flt_devna, flt_gp;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vec_legal_check u_dut (
    .clk(clk), .rst(rst), .chk_valid(chk_valid),
    .fpu_emulate(fpu_emulate), .vec_state_en(vec_state_en),
    .feature_present(feature_present), .ctx_switched(ctx_switched),
    .pfx_lock(pfx_lock), .pfx_rep(pfx_rep), .pfx_repne(pfx_repne),
    .src_is_mem(src_is_mem), .ea_low(ea_low),
    .res_valid(res_valid), .res_ok(res_ok), .flt_undef(flt_undef),
    .flt_devna(flt_devna), .flt_gp(flt_gp)
  );

  // expected outputs {valid, ok, undef, devna, gp} for the next cycle
  logic [4:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [4:0] ref_verdict(input logic v, input logic [6:0] c,
                                             input logic mem, input logic [3:0] a);
    // c = {emulate, state_en, feature, switched, lock, rep, repne}
    if (!v) return 5'b00000;
    if (c[6]) return 5'b10100;
    if (!c[5] || !c[4]) return 5'b10100;
    if (c[2] || c[1] || c[0]) return 5'b10100;
    if (c[3]) return 5'b10010;
    if (mem && a != 4'd0) return 5'b10001;
    return 5'b11000;
  endfunction

  function automatic string ref_tag(input logic v, input logic [6:0] c,
                                    input logic mem, input logic [3:0] a);
    if (!v) return "R9";
    if (c[6]) return (c[3] || (mem && a != 0)) ? "R1/R7" : "R1";
    if (!c[5] || !c[4]) return "R2";
    if (c[2] || c[1] || c[0]) return (c[3] ? "R3/R7" : "R3");
    if (c[3]) return (mem && a != 0) ? "R4/R7" : "R4";
    if (mem && a != 0) return "R5";
    if (!mem && a != 0) return "R6";
    return mem ? "R5/R8" : "R8";
  endfunction

  task automatic compare(input logic [4:0] exp, input string tag);
    logic [4:0] act;
    act = {res_valid, res_ok, flt_undef, flt_devna, flt_gp};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {valid,ok,undef,devna,gp} actual %b expected %b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, then check the previous cycle's expectation at the next negedge
  task automatic step(input logic v, input logic [6:0] c, input logic mem, input logic [3:0] a);
    chk_valid = v;
    {fpu_emulate, vec_state_en, feature_present, ctx_switched, pfx_lock, pfx_rep, pfx_repne} = c;
    src_is_mem = mem;
    ea_low = a;
    exp_q.push_back(ref_verdict(v, c, mem, a));
    tag_q.push_back(ref_tag(v, c, mem, a));
    @(negedge clk);
    compare(exp_q.pop_front(), tag_q.pop_front());
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R9: watchdog expired, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    chk_valid = 1'b1;
    repeat (3) @(negedge clk);
    compare(5'b00000, "R10");
    rst = 1'b0;
    chk_valid = 1'b0;
    @(negedge clk);
    compare(5'b00000, "R10");

    // exhaustive control/prefix sweep, both operand forms, aligned and misaligned
    for (int c = 0; c < 128; c++) begin
      for (int m = 0; m < 2; m++) begin
        step(1'b1, c[6:0], m[0], 4'd0);
        step(1'b1, c[6:0], m[0], 4'($urandom_range(1, 15)));
        if (c % 16 == 0) step(1'b0, c[6:0], m[0], 4'hF);
      end
    end

    // each single misaligned bit on a legal instruction (R5) and register form (R6)
    for (int b = 0; b < 4; b++) begin
      step(1'b1, 7'b0110000, 1'b1, 4'(1 << b));
      step(1'b1, 7'b0110000, 1'b0, 4'(1 << b));
    end

    // random mix, with gaps
    for (int i = 0; i < 400; i++) begin
      logic [6:0] c;
      c = 7'($urandom);
      if (i % 2 == 0) c = c & 7'b0111000 | 7'b0110000;
      step(1'($urandom_range(0, 3) != 0), c, 1'($urandom), 4'($urandom));
    end
    step(1'b0, 7'b0110000, 1'b0, 4'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule